// File: doc/BRIEF.md
# Tagged Round-Robin Request Switch

This block merges N requester ports onto one downstream request channel and returns each response to the port that issued it. In every cycle it samples all input ports together. If any of them is valid, it stores their payloads and a per-port valid mask as one batch entry in a small FIFO. Requests that arrive together are therefore drained together, and no request from a later batch leaves before every request of the earlier batch has gone.

Only the batch at the FIFO head takes part in arbitration. A scan starts at a cursor, wraps modulo N and grants the first set bit. One request leaves per cycle. When N is greater than 1, the outgoing tag is the incoming tag with the granted port index appended below it. On the way back, the switch reads the destination port from the low bits of the response tag, drops those bits, and presents the response on that port one cycle later. No lookup table is needed.

Top module: `batch_rr_switch`

## Requirements
- R1: A batch is stored at a clock edge when at least one bit of `req_valid_i` is set and `req_ready_o` is high. The entry holds every port's payload and tag, and the valid mask equals `req_valid_i`.
- R2: A cycle with no valid input stores nothing, and no downstream request comes from it.
- R3: The batch FIFO holds `DEPTH` entries. While it is full, `req_ready_o` is low, and requests offered in that cycle are dropped and never appear downstream.
- R4: Only the head batch is arbitrated. The scan runs over port indices cursor, cursor+1, … modulo N, and the first index whose mask bit is set wins the grant.
- R5: At most one request leaves per accepted cycle (`out_valid_o && out_ready_i`). Its mask bit is then cleared. The head batch is popped only when its mask becomes empty, so all of its requests leave before any request of a later batch.
- R6: For N > 1, `out_tag_o` = {incoming tag, granted port index}, with the index in the low ceil(log2 N) bits. For N = 1, the tag passes through unchanged.
- R7: In round-robin mode (`ARB_MODE` = ARB_RR), each grant sets the cursor to (granted index + 1) mod N. In fixed-priority mode the cursor stays 0, so the lowest valid index always wins.
- R8: While `out_valid_o` is high and `out_ready_i` is low, `out_valid_o`, `out_data_o` and `out_tag_o` hold their values into the next cycle.
- R9: A response is accepted in every cycle in which `rsp_valid_i` is high. On the next cycle, exactly one bit of `rsp_valid_o` is set, at the port given by the low ceil(log2 N) bits of `rsp_tag_i`. That port carries `rsp_data_i`, and its tag is `rsp_tag_i` shifted right by ceil(log2 N). With no input response, `rsp_valid_o` is 0.
- R10: While `rst_ni` is low, `out_valid_o` is 0, `rsp_valid_o` is 0 and `req_ready_o` is 1.
- R11: A request captured into an empty switch drives `out_valid_o` in the cycle right after its capture edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | N_PORTS | Per-port request valid |
| req_data_i | input | N_PORTS*DATA_W | Per-port request payload, port p at bits [p*DATA_W +: DATA_W] |
| req_tag_i | input | N_PORTS*TAG_W | Per-port request tag, port p at bits [p*TAG_W +: TAG_W] |
| req_ready_o | output | 1 | Shared input ready; low while the batch FIFO is full |
| out_valid_o | output | 1 | Downstream request valid |
| out_ready_i | input | 1 | Downstream ready |
| out_data_o | output | DATA_W | Downstream request payload |
| out_tag_o | output | TAG_W+ceil(log2 N_PORTS) | Widened downstream tag |
| rsp_valid_i | input | 1 | Returning response valid |
| rsp_data_i | input | DATA_W | Returning response payload |
| rsp_tag_i | input | TAG_W+ceil(log2 N_PORTS) | Returning widened tag |
| rsp_valid_o | output | N_PORTS | Per-port response valid, at most one bit set |
| rsp_data_o | output | N_PORTS*DATA_W | Per-port response payload |
| rsp_tag_o | output | N_PORTS*TAG_W | Per-port response tag, port bits removed |

## Verification
A request becomes visible downstream right after the edge that captures it if the FIFO was empty. Otherwise it becomes visible after the edge that retires the last request ahead of it. A response shows up exactly one edge after it is accepted. The bench drives stimulus just after a rising edge and samples at the falling edge. It stamps each response with the cycle in which it was offered and requires delivery in the following cycle. It predicts the request order with its own cursor model, so any order, tag or stall mismatch shows up as a queue mismatch. A dedicated check confirms that `out_valid_o` rises one cycle after capture into an empty FIFO.

// File: rtl/bsw_pkg.sv
package bsw_pkg;
  typedef enum logic {ARB_PRIO = 1'b0, ARB_RR = 1'b1} arb_mode_e;

  // bits needed to carry a port index; 0 for a single port
  function automatic int idx_bits(input int n);
    return (n > 1) ? $clog2(n) : 0;
  endfunction
endpackage

// File: rtl/bsw_batch_fifo.sv
module bsw_batch_fifo #(
  parameter int N      = 4,
  parameter int DATA_W = 8,
  parameter int TAG_W  = 4,
  parameter int DEPTH  = 4,
  parameter int PIDX_W = 2,
  parameter int FILL_W = 3
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                push_i,
  input  logic [N-1:0]        push_mask_i,
  input  logic [N*DATA_W-1:0] push_data_i,
  input  logic [N*TAG_W-1:0]  push_tag_i,
  input  logic                clr_i,
  input  logic [PIDX_W-1:0]   clr_idx_i,
  output logic [N-1:0]        head_mask_o,
  output logic [N*DATA_W-1:0] head_data_o,
  output logic [N*TAG_W-1:0]  head_tag_o,
  output logic                full_o,
  output logic [FILL_W-1:0]   fill_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [N*DATA_W-1:0] data_mem [DEPTH];
  logic [N*TAG_W-1:0]  tag_mem  [DEPTH];
  logic [N-1:0]        mask_mem [DEPTH];
  logic [AW-1:0]       wr_q, rd_q;
  logic [FILL_W-1:0]   fill_q;
  logic [N-1:0]        left_mask;
  logic                pop;

  function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  assign head_mask_o = (fill_q != '0) ? mask_mem[rd_q] : '0;
  assign head_data_o = data_mem[rd_q];
  assign head_tag_o  = tag_mem[rd_q];
  assign full_o      = (fill_q == FILL_W'(DEPTH));
  assign fill_o      = fill_q;

  // mask that remains after the granted bit is retired
  assign left_mask = head_mask_o & ~(N'(1) << clr_idx_i);
  assign pop       = clr_i && (left_mask == '0);

  always_ff @(posedge clk_i) begin
    if (push_i) begin
      data_mem[wr_q] <= push_data_i;
      tag_mem[wr_q]  <= push_tag_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q   <= '0;
      rd_q   <= '0;
      fill_q <= '0;
      for (int i = 0; i < DEPTH; i++) mask_mem[i] <= '0;
    end else begin
      if (clr_i)  mask_mem[rd_q] <= left_mask;
      if (push_i) mask_mem[wr_q] <= push_mask_i;
      if (push_i) wr_q <= ptr_inc(wr_q);
      if (pop)    rd_q <= ptr_inc(rd_q);
      case ({push_i, pop})
        2'b10:   fill_q <= fill_q + FILL_W'(1);
        2'b01:   fill_q <= fill_q - FILL_W'(1);
        default: fill_q <= fill_q;
      endcase
    end
  end
endmodule

// File: rtl/bsw_arbiter.sv
module bsw_arbiter #(
  parameter int                  N      = 4,
  parameter int                  PIDX_W = 2,
  parameter bsw_pkg::arb_mode_e  MODE   = bsw_pkg::ARB_RR
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N-1:0]      mask_i,
  input  logic              adv_i,
  output logic              gnt_valid_o,
  output logic [PIDX_W-1:0] gnt_idx_o,
  output logic [PIDX_W-1:0] cursor_o
);
  // wrap-around scan starting at the cursor
  always_comb begin
    gnt_valid_o = 1'b0;
    gnt_idx_o   = '0;
    for (int i = 0; i < N; i++) begin
      automatic int j = (int'(cursor_o) + i) % N;
      if (!gnt_valid_o && mask_i[j]) begin
        gnt_valid_o = 1'b1;
        gnt_idx_o   = PIDX_W'(j);
      end
    end
  end

  if (MODE == bsw_pkg::ARB_RR) begin : g_rr
    logic [PIDX_W-1:0] cursor_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    cursor_q <= '0;
      else if (adv_i) cursor_q <= (int'(gnt_idx_o) == N - 1) ? '0 : gnt_idx_o + PIDX_W'(1);
    end
    assign cursor_o = cursor_q;
  end else begin : g_prio
    assign cursor_o = '0;
  end
endmodule

// File: rtl/bsw_rsp_route.sv
module bsw_rsp_route #(
  parameter int N      = 4,
  parameter int DATA_W = 8,
  parameter int TAG_W  = 4,
  parameter int SHIFT  = 2,
  parameter int PIDX_W = 2
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     rsp_valid_i,
  input  logic [DATA_W-1:0]        rsp_data_i,
  input  logic [TAG_W+SHIFT-1:0]   rsp_tag_i,
  output logic [N-1:0]             rsp_valid_o,
  output logic [N*DATA_W-1:0]      rsp_data_o,
  output logic [N*TAG_W-1:0]       rsp_tag_o
);
  logic [PIDX_W-1:0] dst;
  logic [TAG_W-1:0]  tag_strip;
  logic [N-1:0]      valid_q;
  logic [DATA_W-1:0] data_q;
  logic [TAG_W-1:0]  tag_q;

  if (SHIFT > 0) begin : g_split
    assign dst       = rsp_tag_i[SHIFT-1:0];
    assign tag_strip = rsp_tag_i[TAG_W+SHIFT-1:SHIFT];
  end else begin : g_pass
    assign dst       = '0;
    assign tag_strip = rsp_tag_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) valid_q <= '0;
    else         valid_q <= rsp_valid_i ? (N'(1) << dst) : '0;
  end

  always_ff @(posedge clk_i) begin
    if (rsp_valid_i) begin
      data_q <= rsp_data_i;
      tag_q  <= tag_strip;
    end
  end

  assign rsp_valid_o = valid_q;
  for (genvar p = 0; p < N; p++) begin : g_lane
    assign rsp_data_o[p*DATA_W +: DATA_W] = data_q;
    assign rsp_tag_o[p*TAG_W +: TAG_W]    = tag_q;
  end
endmodule

// File: rtl/batch_rr_switch.sv
module batch_rr_switch #(
  parameter int                 N_PORTS  = 4,
  parameter int                 DATA_W   = 8,
  parameter int                 TAG_W    = 4,
  parameter int                 DEPTH    = 4,
  parameter bsw_pkg::arb_mode_e ARB_MODE = bsw_pkg::ARB_RR,
  parameter int                 SHIFT    = bsw_pkg::idx_bits(N_PORTS),
  parameter int                 OTAG_W   = TAG_W + SHIFT
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [N_PORTS-1:0]          req_valid_i,
  input  logic [N_PORTS*DATA_W-1:0]   req_data_i,
  input  logic [N_PORTS*TAG_W-1:0]    req_tag_i,
  output logic                        req_ready_o,
  output logic                        out_valid_o,
  input  logic                        out_ready_i,
  output logic [DATA_W-1:0]           out_data_o,
  output logic [OTAG_W-1:0]           out_tag_o,
  input  logic                        rsp_valid_i,
  input  logic [DATA_W-1:0]           rsp_data_i,
  input  logic [OTAG_W-1:0]           rsp_tag_i,
  output logic [N_PORTS-1:0]          rsp_valid_o,
  output logic [N_PORTS*DATA_W-1:0]   rsp_data_o,
  output logic [N_PORTS*TAG_W-1:0]    rsp_tag_o
);
  localparam int PIDX_W = (SHIFT > 0) ? SHIFT : 1;
  localparam int FILL_W = $clog2(DEPTH + 1);

  logic [N_PORTS-1:0]        head_mask;
  logic [N_PORTS*DATA_W-1:0] head_data;
  logic [N_PORTS*TAG_W-1:0]  head_tag;
  logic                      fifo_full;
  logic [FILL_W-1:0]         fill_w;
  logic                      gnt_valid;
  logic [PIDX_W-1:0]         gnt_idx_w;
  logic [PIDX_W-1:0]         cursor_w;
  logic                      push, fire;
  logic [TAG_W-1:0]          sel_tag;

  assign req_ready_o = !fifo_full;
  assign push        = (|req_valid_i) && !fifo_full;
  assign fire        = gnt_valid && out_ready_i;

  bsw_batch_fifo #(
    .N(N_PORTS), .DATA_W(DATA_W), .TAG_W(TAG_W), .DEPTH(DEPTH),
    .PIDX_W(PIDX_W), .FILL_W(FILL_W)
  ) u_fifo (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .push_i      (push),
    .push_mask_i (req_valid_i),
    .push_data_i (req_data_i),
    .push_tag_i  (req_tag_i),
    .clr_i       (fire),
    .clr_idx_i   (gnt_idx_w),
    .head_mask_o (head_mask),
    .head_data_o (head_data),
    .head_tag_o  (head_tag),
    .full_o      (fifo_full),
    .fill_o      (fill_w)
  );

  bsw_arbiter #(.N(N_PORTS), .PIDX_W(PIDX_W), .MODE(ARB_MODE)) u_arb (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .mask_i      (head_mask),
    .adv_i       (fire),
    .gnt_valid_o (gnt_valid),
    .gnt_idx_o   (gnt_idx_w),
    .cursor_o    (cursor_w)
  );

  assign out_valid_o = gnt_valid;
  assign out_data_o  = head_data[gnt_idx_w*DATA_W +: DATA_W];
  assign sel_tag     = head_tag[gnt_idx_w*TAG_W +: TAG_W];

  if (SHIFT > 0) begin : g_widen
    assign out_tag_o = {sel_tag, gnt_idx_w};
  end else begin : g_keep
    assign out_tag_o = sel_tag;
  end

  bsw_rsp_route #(
    .N(N_PORTS), .DATA_W(DATA_W), .TAG_W(TAG_W), .SHIFT(SHIFT), .PIDX_W(PIDX_W)
  ) u_rsp (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rsp_valid_i (rsp_valid_i),
    .rsp_data_i  (rsp_data_i),
    .rsp_tag_i   (rsp_tag_i),
    .rsp_valid_o (rsp_valid_o),
    .rsp_data_o  (rsp_data_o),
    .rsp_tag_o   (rsp_tag_o)
  );
endmodule

// File: rtl/bsw_checker.sv
module bsw_checker #(
  parameter int                 N      = 4,
  parameter int                 DATA_W = 8,
  parameter int                 OTAG_W = 6,
  parameter int                 DEPTH  = 4,
  parameter int                 FILL_W = 3,
  parameter int                 PIDX_W = 2,
  parameter bsw_pkg::arb_mode_e MODE   = bsw_pkg::ARB_RR
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_ready_o,
  input logic              out_valid_o,
  input logic              out_ready_i,
  input logic [DATA_W-1:0] out_data_o,
  input logic [OTAG_W-1:0] out_tag_o,
  input logic              rsp_valid_i,
  input logic [N-1:0]      rsp_valid_o,
  input logic [FILL_W-1:0] fill_w,
  input logic [PIDX_W-1:0] gnt_idx_w,
  input logic [PIDX_W-1:0] cursor_w
);
  p_no_overflow_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_w <= FILL_W'(DEPTH));

  p_ready_full_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_ready_o |-> fill_w == FILL_W'(DEPTH));

  p_empty_idle_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_w == '0 |-> !out_valid_o);

  p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(out_data_o) && $stable(out_tag_o));

  p_cursor_step_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (MODE == bsw_pkg::ARB_RR) && out_valid_o && out_ready_i |=>
      cursor_w == PIDX_W'((int'($past(gnt_idx_w)) + 1) % N));

  p_cursor_fixed_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (MODE == bsw_pkg::ARB_PRIO) |-> cursor_w == '0);

  p_rsp_onehot_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(rsp_valid_o));

  p_rsp_next_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_i |=> $countones(rsp_valid_o) == 1);

  p_rsp_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rsp_valid_i |=> rsp_valid_o == '0);
endmodule

bind batch_rr_switch bsw_checker #(
  .N(N_PORTS), .DATA_W(DATA_W), .OTAG_W(OTAG_W), .DEPTH(DEPTH),
  .FILL_W(FILL_W), .PIDX_W(PIDX_W), .MODE(ARB_MODE)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_ready_o (req_ready_o),
  .out_valid_o (out_valid_o),
  .out_ready_i (out_ready_i),
  .out_data_o  (out_data_o),
  .out_tag_o   (out_tag_o),
  .rsp_valid_i (rsp_valid_i),
  .rsp_valid_o (rsp_valid_o),
  .fill_w      (fill_w),
  .gnt_idx_w   (gnt_idx_w),
  .cursor_w    (cursor_w)
);

// File: tb/tb_batch_rr_switch.sv
module tb_batch_rr_switch;
  localparam int N  = 4;
  localparam int DW = 8;
  localparam int TW = 4;
  localparam int IW = 2;
  localparam int OW = TW + IW;
  localparam int EW = DW + OW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [N-1:0]    req_valid = '0;
  logic [N*DW-1:0] req_data  = '0;
  logic [N*TW-1:0] req_tag   = '0;
  logic            out_ready = 1'b0;
  logic            rsp_valid = 1'b0;
  logic [DW-1:0]   rsp_data  = '0;
  logic [OW-1:0]   rsp_tag   = '0;

  logic            rdy_r, rdy_p, ov_r, ov_p;
  logic [DW-1:0]   od_r, od_p;
  logic [OW-1:0]   ot_r, ot_p;
  logic [N-1:0]    rv_r, rv_p;
  logic [N*DW-1:0] rd_r, rd_p;
  logic [N*TW-1:0] rt_r, rt_p;

  batch_rr_switch #(.N_PORTS(N), .DATA_W(DW), .TAG_W(TW), .DEPTH(4),
                    .ARB_MODE(bsw_pkg::ARB_RR)) dut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_data_i(req_data),
    .req_tag_i(req_tag), .req_ready_o(rdy_r), .out_valid_o(ov_r), .out_ready_i(out_ready),
    .out_data_o(od_r), .out_tag_o(ot_r), .rsp_valid_i(rsp_valid), .rsp_data_i(rsp_data),
    .rsp_tag_i(rsp_tag), .rsp_valid_o(rv_r), .rsp_data_o(rd_r), .rsp_tag_o(rt_r));

  batch_rr_switch #(.N_PORTS(N), .DATA_W(DW), .TAG_W(TW), .DEPTH(4),
                    .ARB_MODE(bsw_pkg::ARB_PRIO)) dut_prio (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_data_i(req_data),
    .req_tag_i(req_tag), .req_ready_o(rdy_p), .out_valid_o(ov_p), .out_ready_i(out_ready),
    .out_data_o(od_p), .out_tag_o(ot_p), .rsp_valid_i(rsp_valid), .rsp_data_i(rsp_data),
    .rsp_tag_i(rsp_tag), .rsp_valid_o(rv_p), .rsp_data_o(rd_p), .rsp_tag_o(rt_p));

  int tests = 0;
  int fails = 0;
  int cyc = 0;
  bit done = 1'b0;
  int m_cur = 0;

  logic [EW-1:0] exp_rr[$];
  logic [EW-1:0] exp_pr[$];
  int            rexp_port[$];
  logic [DW-1:0] rexp_data[$];
  logic [TW-1:0] rexp_tag[$];
  int            rexp_stamp[$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // expected downstream order for one captured batch (R4 R5 R6 R7)
  task automatic model_batch(input logic [N-1:0] mask);
    logic [N-1:0] m = mask;
    int c = m_cur;
    while (m != '0) begin
      for (int i = 0; i < N; i++) begin
        automatic int j = (c + i) % N;
        if (m[j]) begin
          exp_rr.push_back({req_data[j*DW +: DW], req_tag[j*TW +: TW], IW'(j)});
          m[j] = 1'b0;
          c = (j + 1) % N;
          break;
        end
      end
    end
    m_cur = c;
    for (int j = 0; j < N; j++)
      if (mask[j]) exp_pr.push_back({req_data[j*DW +: DW], req_tag[j*TW +: TW], IW'(j)});
  endtask

  // called at posedge+1; one cycle long
  task automatic drive(input logic [N-1:0] mask, input logic [7:0] base);
    req_valid = mask;
    for (int p = 0; p < N; p++) begin
      req_data[p*DW +: DW] = base + 8'(p);
      req_tag[p*TW +: TW]  = TW'(base * 3 + 8'(p));
    end
    if (rdy_r && mask != '0) model_batch(mask);
    @(posedge clk); #1;
    req_valid = '0;
  endtask

  task automatic rsp_send(input int port, input logic [TW-1:0] t, input logic [DW-1:0] d);
    rsp_valid = 1'b1;
    rsp_data  = d;
    rsp_tag   = {t, IW'(port)};
    rexp_port.push_back(port);
    rexp_data.push_back(d);
    rexp_tag.push_back(t);
    rexp_stamp.push_back(cyc);
    @(posedge clk); #1;
    rsp_valid = 1'b0;
  endtask

  // request monitors (R4 R5 R6 R7 R8)
  logic          pv_r = 0, pr_r = 0, pv_p = 0, pr_p = 0;
  logic [EW-1:0] pg_r, pg_p;
  always @(negedge clk) if (rst_n && !done) begin
    if (pv_r && !pr_r)
      check(ov_r && {od_r, ot_r} == pg_r, "R8", "rr hold", {od_r, ot_r}, pg_r);
    if (ov_r && out_ready) begin
      if (exp_rr.size() == 0) check(1'b0, "R2", "rr unexpected request", {od_r, ot_r}, 0);
      else begin
        automatic logic [EW-1:0] e = exp_rr.pop_front();
        check({od_r, ot_r} == e, "R4/R6/R7", "rr order", {od_r, ot_r}, e);
      end
    end
    pv_r = ov_r; pr_r = out_ready; pg_r = {od_r, ot_r};
  end

  always @(negedge clk) if (rst_n && !done) begin
    if (pv_p && !pr_p)
      check(ov_p && {od_p, ot_p} == pg_p, "R8", "prio hold", {od_p, ot_p}, pg_p);
    if (ov_p && out_ready) begin
      if (exp_pr.size() == 0) check(1'b0, "R2", "prio unexpected request", {od_p, ot_p}, 0);
      else begin
        automatic logic [EW-1:0] e = exp_pr.pop_front();
        check({od_p, ot_p} == e, "R5/R7", "prio order", {od_p, ot_p}, e);
      end
    end
    pv_p = ov_p; pr_p = out_ready; pg_p = {od_p, ot_p};
  end

  // response monitor (R9)
  always @(negedge clk) if (rst_n && !done) begin
    automatic int cnt = $countones(rv_r);
    if (cnt > 1) check(1'b0, "R9", "several ports valid", rv_r, 0);
    else if (cnt == 1) begin
      if (rexp_port.size() == 0) check(1'b0, "R9", "unexpected response", rv_r, 0);
      else begin
        automatic int p = rexp_port.pop_front();
        automatic logic [DW-1:0] d = rexp_data.pop_front();
        automatic logic [TW-1:0] t = rexp_tag.pop_front();
        automatic int s = rexp_stamp.pop_front();
        check(rv_r == N'(1) << p, "R9", "port", rv_r, N'(1) << p);
        check(rd_r[p*DW +: DW] == d, "R9", "data", rd_r[p*DW +: DW], d);
        check(rt_r[p*TW +: TW] == t, "R9", "stripped tag", rt_r[p*TW +: TW], t);
        check(cyc == s + 1, "R9", "delivery cycle", cyc, s + 1);
      end
    end else if (rexp_port.size() != 0 && cyc > rexp_stamp[0] + 1)
      check(1'b0, "R9", "late response", cyc, rexp_stamp[0] + 1);
  end

  task automatic wait_drain();
    while (exp_rr.size() != 0 || exp_pr.size() != 0) begin
      @(posedge clk); #1;
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R10: reset state
    check(!ov_r && !ov_p, "R10", "out_valid in reset", ov_r, 0);
    check(rv_r == '0, "R10", "rsp_valid in reset", rv_r, 0);
    check(rdy_r && rdy_p, "R10", "ready in reset", rdy_r, 1);
    @(posedge clk); #1;
    rst_n = 1'b1;
    @(posedge clk); #1;
    out_ready = 1'b1;

    // R11: capture into empty switch, visible next cycle
    drive(4'b0001, 8'h10);
    @(negedge clk);
    check(ov_r == 1'b1, "R11", "out_valid after capture", ov_r, 1);
    @(posedge clk); #1;
    wait_drain();

    // R1 R4 R5 R7: full and partial batches back to back
    for (int k = 0; k < 4; k++) drive(4'b1111, 8'h20 + 8'(k * 8));
    drive(4'b1010, 8'h50);
    drive(4'b0101, 8'h60);
    drive(4'b0000, 8'h68);
    drive(4'b0100, 8'h70);
    drive(4'b1001, 8'h78);
    wait_drain();

    // R3: fill with downstream stalled, fifth batch dropped; R8 holds
    out_ready = 1'b0;
    drive(4'b0110, 8'h80);
    drive(4'b1000, 8'h88);
    drive(4'b0011, 8'h90);
    drive(4'b1101, 8'h98);
    check(!rdy_r && !rdy_p, "R3", "ready while full", rdy_r, 0);
    drive(4'b1111, 8'hA0);
    repeat (3) begin @(posedge clk); #1; end
    while (exp_rr.size() != 0 || exp_pr.size() != 0) begin
      out_ready = ~out_ready;
      @(posedge clk); #1;
    end
    out_ready = 1'b1;

    // R2: idle inputs produce nothing
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      check(!ov_r && !ov_p, "R2", "idle out_valid", ov_r, 0);
    end
    @(posedge clk); #1;

    // R9: responses to every port, back to back, then isolated
    rsp_send(0, 4'h3, 8'hC0);
    rsp_send(3, 4'hF, 8'hC1);
    rsp_send(1, 4'h0, 8'hC2);
    rsp_send(2, 4'hA, 8'hC3);
    @(posedge clk); #1;
    rsp_send(2, 4'h5, 8'hC4);
    fork
      drive(4'b1011, 8'hD0);
      rsp_send(1, 4'h7, 8'hC5);
    join
    repeat (3) begin @(posedge clk); #1; end
    wait_drain();
    @(negedge clk);
    check(rexp_port.size() == 0, "R9", "responses outstanding", rexp_port.size(), 0);
    check(!ov_r && exp_rr.size() == 0, "R5", "drained", ov_r, 0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      tests++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule